// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits next to the main interrupt controller in a power domain that stays on. Each shared peripheral interrupt line passes straight through to the main controller whatever the mask state.

For each of two CPUs the block also keeps a 128-bit wakeup-enable mask. When any asserted interrupt line has its enable bit set in a CPU's mask, the block raises a wakeup request for that CPU. A power controller can then bring that CPU out of a low-power state.

The host programs the masks through a small memory-mapped register port that has separate read and write strobes. Writes always carry a full 32-bit word. To change a single bit, the host reads the word, modifies it and writes it back.

Top module: `wkg_wakeup_top`

## Requirements
- R1: `irq_out` equals `irq_in` combinationally at all times, whatever the mask contents.
- R2: While `rst` is high at a clock edge, every enable bit of both CPUs is cleared to 0. After reset, every register reads 0 and `wakeup_req` is 0.
- R3: Register k (k = 0..3) of CPU c (c = 0..1) sits at byte address c*0x400 + 4*k. Interrupt n maps to register n>>5, bit n mod 32.
- R4: `wr_en` high at a clock edge with a mapped address stores all 32 bits of `wdata` into that register.
- R5: `rd_en` high at a clock edge makes `rdata` show the addressed register's contents from before that edge, starting one cycle later. When `rd_en` was low at the previous edge, `rdata` is 0. A read and a write to the same address in the same cycle therefore return the old value.
- R6: `wakeup_req[c]` is combinationally the OR over all n of (`irq_in[n]` AND enable bit n of CPU c).
- R7: A write to one CPU's bank leaves the other CPU's bank unchanged.
- R8: A read of an unmapped address returns 0, and a write to it changes nothing. Unmapped means a CPU index of 2 or more, an offset of 0x10 or more within a bank, or `addr[1:0]` not equal to 0.
- R9: Writing all ones to all four registers of a CPU enables wakeup from every line for that CPU. Writing all zeros disables every line for that CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 128 | Shared peripheral interrupt lines |
| irq_out | output | 128 | Lines forwarded to the main controller |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wakeup_req | output | 2 | Wakeup request per CPU |

## Verification
The pass-through and the wakeup requests are combinational, so the bench checks them one time unit after it drives new inputs on the falling edge, against the mask stored at the last rising edge. A mask write therefore shows up in `wakeup_req` only in the step after the write. Read data passes through one register, so the bench checks `rdata` on the falling edge that follows the rising edge where `rd_en` was sampled, before it drives the next inputs.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
    localparam int WKG_CPUS   = 2;
    localparam int WKG_IRQS   = 128;
    localparam int WKG_WORD   = 32;
    localparam int WKG_ADDR_W = 12;
    localparam int WKG_STRIDE = 'h400;
    localparam int WKG_REGS   = WKG_IRQS / WKG_WORD;
    localparam int REG_IDX_W  = (WKG_REGS > 1) ? $clog2(WKG_REGS) : 1;
    localparam int CPU_IDX_W  = (WKG_CPUS > 1) ? $clog2(WKG_CPUS) : 1;

    typedef struct packed {
        logic                 hit;
        logic [CPU_IDX_W-1:0] cpu;
        logic [REG_IDX_W-1:0] idx;
    } wkg_sel_t;

    typedef enum logic [1:0] {ACC_IDLE, ACC_READ, ACC_WRITE, ACC_BOTH} wkg_acc_t;

    function automatic wkg_sel_t wkg_decode(input logic [WKG_ADDR_W-1:0] a);
        wkg_sel_t s;
        int       cpu_n;
        int       off;
        cpu_n = int'(a) / WKG_STRIDE;
        off   = int'(a) % WKG_STRIDE;
        s.hit = (a[1:0] == 2'b00) && (cpu_n < WKG_CPUS) && (off < WKG_REGS * 4);
        s.cpu = cpu_n[CPU_IDX_W-1:0];
        s.idx = off[REG_IDX_W+1:2];
        return s;
    endfunction
endpackage

// File: rtl/wkg_addr_dec.sv
module wkg_addr_dec
    import wkg_pkg::*;
(
    input  logic [WKG_ADDR_W-1:0] addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    output wkg_sel_t              sel,
    output wkg_acc_t              acc
);
    always_comb begin
        sel = wkg_decode(addr);
        unique case ({wr_en, rd_en})
            2'b00:   acc = ACC_IDLE;
            2'b01:   acc = ACC_READ;
            2'b10:   acc = ACC_WRITE;
            default: acc = ACC_BOTH;
        endcase
    end
endmodule

// File: rtl/wkg_mask_bank.sv
module wkg_mask_bank
    import wkg_pkg::*;
#(
    parameter int CPU_ID = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  wkg_sel_t            sel,
    input  wkg_acc_t            acc,
    input  logic [WKG_WORD-1:0] wdata,
    output logic [WKG_IRQS-1:0] mask
);
    logic bank_wr;
    assign bank_wr = sel.hit && (sel.cpu == CPU_IDX_W'(CPU_ID)) &&
                     (acc == ACC_WRITE || acc == ACC_BOTH);

    for (genvar k = 0; k < WKG_REGS; k++) begin : g_reg
        logic [WKG_WORD-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (bank_wr && sel.idx == REG_IDX_W'(k)) begin
                word_q <= wdata;
            end
        end
        assign mask[k*WKG_WORD +: WKG_WORD] = word_q;
    end
endmodule

// File: rtl/wkg_wake_merge.sv
module wkg_wake_merge
    import wkg_pkg::*;
(
    input  logic [WKG_IRQS-1:0] irq,
    input  logic [WKG_IRQS-1:0] mask,
    output logic                wake
);
    assign wake = |(irq & mask);
endmodule

// File: rtl/wkg_wakeup_top.sv
module wkg_wakeup_top
    import wkg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WKG_IRQS-1:0]   irq_in,
    output logic [WKG_IRQS-1:0]   irq_out,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [WKG_ADDR_W-1:0] addr,
    input  logic [WKG_WORD-1:0]   wdata,
    output logic [WKG_WORD-1:0]   rdata,
    output logic [WKG_CPUS-1:0]   wakeup_req
);
    wkg_sel_t            sel;
    wkg_acc_t            acc;
    logic [WKG_IRQS-1:0] masks [WKG_CPUS];
    logic [WKG_WORD-1:0] rd_word;

    assign irq_out = irq_in;

    wkg_addr_dec i_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .sel   (sel),
        .acc   (acc)
    );

    for (genvar c = 0; c < WKG_CPUS; c++) begin : g_cpu
        wkg_mask_bank #(.CPU_ID(c)) i_bank (
            .clk   (clk),
            .rst   (rst),
            .sel   (sel),
            .acc   (acc),
            .wdata (wdata),
            .mask  (masks[c])
        );
        wkg_wake_merge i_wake (
            .irq  (irq_in),
            .mask (masks[c]),
            .wake (wakeup_req[c])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < WKG_CPUS; c++) begin
            if (sel.hit && sel.cpu == CPU_IDX_W'(c)) begin
                rd_word = masks[c][sel.idx*WKG_WORD +: WKG_WORD];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc == ACC_READ || acc == ACC_BOTH) begin
            rdata <= rd_word;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/wkg_wakeup_chk.sv
module wkg_wakeup_chk
    import wkg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [WKG_IRQS-1:0]   irq_in,
    input logic [WKG_IRQS-1:0]   irq_out,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [WKG_ADDR_W-1:0] addr,
    input logic [WKG_WORD-1:0]   wdata,
    input logic [WKG_WORD-1:0]   rdata,
    input logic [WKG_CPUS-1:0]   wakeup_req
);
    logic in_map;
    always_comb begin
        in_map = (addr[1:0] == 2'b00) &&
                 ((int'(addr) / WKG_STRIDE) < WKG_CPUS) &&
                 ((int'(addr) % WKG_STRIDE) < WKG_REGS * 4);
    end

    p_passthru_r1: assert property (@(posedge clk) irq_out == irq_in);

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wakeup_req == '0 && rdata == '0));

    p_idle_read_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0);

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_map) |=> rdata == '0);

    p_wake_cause_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_in == '0) |-> wakeup_req == '0);

    logic unused_ok;
    assign unused_ok = wr_en ^ (^wdata);
endmodule

bind wkg_wakeup_top wkg_wakeup_chk i_chk (.*);

// File: tb/test_wkg_wakeup_top.sv
module test_wkg_wakeup_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] irq_in = '0;
    logic [127:0] irq_out;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [11:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [1:0]   wakeup_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    wkg_wakeup_top i_wkg_wakeup_top (
        .clk(clk), .rst(rst), .irq_in(irq_in), .irq_out(irq_out),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wakeup_req(wakeup_req)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [11:0] a;
        logic [31:0] wd;
        logic        iv;
        logic [6:0]  in;
        logic [31:0] exp_rd;
        logic [1:0]  exp_wk;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 12'h000, 32'h0000_0001, 1'b0, 7'd0,   32'h0,          2'b00},
        '{1'b0, 1'b1, 12'h000, 32'h0,         1'b1, 7'd0,   32'h0000_0001,  2'b01},
        '{1'b1, 1'b0, 12'h40C, 32'h8000_0000, 1'b1, 7'd127, 32'h0,          2'b00},
        '{1'b0, 1'b1, 12'h40C, 32'h0,         1'b1, 7'd127, 32'h8000_0000,  2'b10},
        '{1'b0, 1'b1, 12'h00C, 32'h0,         1'b0, 7'd0,   32'h0,          2'b00},
        '{1'b1, 1'b0, 12'h800, 32'hFFFF_FFFF, 1'b0, 7'd0,   32'h0,          2'b00},
        '{1'b0, 1'b1, 12'h800, 32'h0,         1'b0, 7'd0,   32'h0,          2'b00},
        '{1'b0, 1'b1, 12'h410, 32'h0,         1'b0, 7'd0,   32'h0,          2'b00},
        '{1'b1, 1'b0, 12'h002, 32'h0000_00FF, 1'b0, 7'd0,   32'h0,          2'b00},
        '{1'b0, 1'b1, 12'h000, 32'h0,         1'b1, 7'd33,  32'h0000_0001,  2'b00},
        '{1'b1, 1'b0, 12'h004, 32'h0000_0002, 1'b1, 7'd33,  32'h0,          2'b00},
        '{1'b0, 1'b0, 12'h000, 32'h0,         1'b1, 7'd33,  32'h0,          2'b01},
        '{1'b1, 1'b1, 12'h004, 32'h0000_0005, 1'b0, 7'd0,   32'h0000_0002,  2'b00},
        '{1'b0, 1'b1, 12'h004, 32'h0,         1'b0, 7'd0,   32'h0000_0005,  2'b00}
    };
    localparam string VTAG [NV] = '{
        "R4", "R3 R5 R6", "R3 R4", "R3 R5 R6", "R7", "R8", "R8", "R8",
        "R8", "R8 R6", "R6", "R6 R4", "R5", "R4"
    };

    task automatic check(input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [11:0] a,
                        input logic [31:0] d, input logic [127:0] irq,
                        input logic [1:0] exp_wk, input logic [31:0] exp_rd,
                        input string tag);
        wr_en = w; rd_en = r; addr = a; wdata = d; irq_in = irq;
        #1;
        check({tag, " wake"}, 128'(wakeup_req), 128'(exp_wk));
        check("R1 passthru", irq_out, irq);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check({tag, " rdata"}, 128'(rdata), 128'(exp_rd));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        irq_in = '1;
        #1;
        check("R2 reset wake", 128'(wakeup_req), 128'(0));
        check("R2 reset rdata", 128'(rdata), 128'(0));

        for (int i = 0; i < NV; i++) begin
            logic [127:0] irq;
            irq = VECS[i].iv ? (128'(1) << VECS[i].in) : 128'(0);
            step(VECS[i].wr, VECS[i].rd, VECS[i].a, VECS[i].wd, irq,
                 VECS[i].exp_wk, VECS[i].exp_rd, VTAG[i]);
        end

        // R9: all ones on CPU 1, then line 77 (register 2, bit 13)
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 12'(12'h400 + 4 * k), 32'hFFFF_FFFF, '0, 2'b00, 32'h0, "R9 set");
        step(1'b0, 1'b0, 12'h0, 32'h0, 128'(1) << 77, 2'b10, 32'h0, "R9 all ones");
        step(1'b0, 1'b1, 12'h408, 32'h0, '0, 2'b00, 32'hFFFF_FFFF, "R9 readback");
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 12'(12'h400 + 4 * k), 32'h0, '0, 2'b00, 32'h0, "R9 clear");
        step(1'b0, 1'b0, 12'h0, 32'h0, '1, 2'b01, 32'h0, "R9 all zeros R7");
        step(1'b0, 1'b0, 12'h0, 32'h0, {64'hA5A5_5A5A_0F0F_F0F0, 64'h1234_5678_9ABC_DEF0},
             2'b00, 32'h0, "R1 pattern");

        // R2: reset mid-run clears CPU 0 word 0
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b1, 12'h000, 32'h0, '1, 2'b00, 32'h0, "R2 clear");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule